// File: doc/BRIEF.md
# PCIe Configuration Intercept Responder

This block sits on the application side of a PCIe endpoint. The link core intercepts configuration reads and writes and presents each one on a valid-qualified request input. The block returns exactly one 33-bit response word for each request. Bit 32 of that word chooses between letting the original access proceed and overriding it. For an overridden write, bits 31:0 become the data written into the configuration register. For an overridden read, bits 31:0 become the completion payload. The response strobe has no ready signal, because the core always accepts it.

A small policy table makes the decision. Each slot has an enable, a dword address, a read/write selector and a 32-bit replacement value, and is loaded through a one-cycle write port. The table lookup happens on the cycle the request is accepted. The response follows a fixed `LATENCY` cycles later. The core never has more than one request outstanding. A request that arrives while a response is still pending is a protocol violation: the block drops it and raises a sticky error flag.

Top module: `cfg_icpt_responder`

## Requirements
- R1: After reset, `rsp_valid` and `proto_err` are 0 and every table slot is disabled, so any request is answered with the all-zero word.
- R2: An accepted request produces exactly one response. `rsp_valid` is high for a single cycle, `LATENCY` clock edges after the edge that accepted the request (1 by default).
- R3: If an enabled slot has the same address and the same type as the request, with `req_is_write` 1 meaning write, the response word has bit 32 = 1 and bits 31:0 equal to that slot's value.
- R4: A request that hits no slot is answered with bit 32 = 0 and bits 31:0 = 0.
- R5: A slot whose type differs from the request type is not a hit, even when its address matches.
- R6: A disabled slot is never a hit.
- R7: When several slots hit, the slot with the lowest index supplies the value.
- R8: A request that arrives while a response is pending, including during the response cycle, gets no response of its own. It also sets `proto_err`, which stays at 1 until reset.
- R9: The decision is taken from the table contents before any table write on the accepting edge. A slot rewrite on that same edge does not change the pending response, but it does apply to later requests.
- R10: `rsp_data` is all zeros whenever `rsp_valid` is 0.
- R11: A request whose byte enable is all zeros always gets the all-zero word. Any nonzero byte enable, including a partial one, leaves the decision to the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, in the same domain as the configuration request channel |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Intercepted request present this cycle |
| req_is_write | input | 1 | 1 for a configuration write, 0 for a read |
| req_addr | input | ADDR_W (10) | Dword address of the target register |
| req_be | input | BE_W (4) | Byte enable mask of the access |
| tbl_we | input | 1 | Write one policy table slot |
| tbl_idx | input | $clog2(ENTRIES) (3) | Slot to write |
| tbl_en | input | 1 | Enable of the slot being written |
| tbl_addr | input | ADDR_W (10) | Match address of the slot being written |
| tbl_is_write | input | 1 | Type of access the slot matches (1 = write) |
| tbl_value | input | DATA_W (32) | Replacement data of the slot being written |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W+1 (33) | Bit 32 = override enable, bits 31:0 = replacement data |
| proto_err | output | 1 | Sticky flag: a request overlapped a pending one |

## Verification
The hardest case to reach from the ports is a slot rewrite that lands on the same edge as the request it would affect. The bench drives the request and a table write to the matching slot in one cycle. It expects the old value in that response and the new value in the next one. A second hard case is the overlapping request. The bench raises another request during the response cycle of the first. It then checks that only one strobe appears, that the error flag sets, and that the flag survives later legal traffic until reset.

// File: rtl/cfg_icpt_responder.sv
module cfg_icpt_responder #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32,
  parameter int BE_W    = 4,
  parameter int LATENCY = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_is_write,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [BE_W-1:0]            req_be,
  input  logic                       tbl_we,
  input  logic [$clog2(ENTRIES)-1:0] tbl_idx,
  input  logic                       tbl_en,
  input  logic [ADDR_W-1:0]          tbl_addr,
  input  logic                       tbl_is_write,
  input  logic [DATA_W-1:0]          tbl_value,
  output logic                       rsp_valid,
  output logic [DATA_W:0]            rsp_data,
  output logic                       proto_err
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic              ent_en  [ENTRIES];
  logic [ADDR_W-1:0] ent_addr[ENTRIES];
  logic              ent_wr  [ENTRIES];
  logic [DATA_W-1:0] ent_val [ENTRIES];

  logic              pending;
  logic [CNT_W-1:0]  wait_cnt;
  logic [DATA_W:0]   word_q;
  logic              hit;
  logic [DATA_W-1:0] hit_val;
  logic              accept;

  assign accept = req_valid && !pending;

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rst_n) begin
        ent_en[i]   <= 1'b0;
        ent_addr[i] <= '0;
        ent_wr[i]   <= 1'b0;
        ent_val[i]  <= '0;
      end else if (tbl_we && tbl_idx == IDX_W'(i)) begin
        ent_en[i]   <= tbl_en;
        ent_addr[i] <= tbl_addr;
        ent_wr[i]   <= tbl_is_write;
        ent_val[i]  <= tbl_value;
      end
    end
  end

  always_comb begin
    hit     = 1'b0;
    hit_val = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_en[i] && ent_addr[i] == req_addr && ent_wr[i] == req_is_write) begin
        hit     = 1'b1;
        hit_val = ent_val[i];
      end
    end
    if (req_be == '0) begin
      hit     = 1'b0;
      hit_val = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      wait_cnt  <= '0;
      word_q    <= '0;
      proto_err <= 1'b0;
    end else begin
      if (req_valid && pending) proto_err <= 1'b1;
      if (accept) begin
        pending  <= 1'b1;
        wait_cnt <= CNT_W'(LATENCY - 1);
        word_q   <= hit ? {1'b1, hit_val} : '0;
      end else if (pending) begin
        if (wait_cnt == '0) pending <= 1'b0;
        else                wait_cnt <= wait_cnt - 1'b1;
      end
    end
  end

  assign rsp_valid = pending && (wait_cnt == '0);
  assign rsp_data  = rsp_valid ? word_q : '0;

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2

  AST_OVERLAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && pending |=> proto_err); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R8

  AST_PASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_data[DATA_W] |-> rsp_data[DATA_W-1:0] == '0); // R4

  generate
    if (LATENCY == 1) begin : g_lat1
      AST_ONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid); // R2
    end
  endgenerate

endmodule

// File: tb/cfg_icpt_responder_tb.sv
module cfg_icpt_responder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 1;
  localparam int NV = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_is_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        tbl_we = 1'b0, tbl_en = 1'b0, tbl_is_write = 1'b0;
  logic [2:0]  tbl_idx = '0;
  logic [9:0]  tbl_addr = '0;
  logic [31:0] tbl_value = '0;
  logic        rsp_valid, proto_err;
  logic [32:0] rsp_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_icpt_responder #(.LATENCY(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_is_write(req_is_write), .req_addr(req_addr), .req_be(req_be),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_en(tbl_en), .tbl_addr(tbl_addr),
    .tbl_is_write(tbl_is_write), .tbl_value(tbl_value),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .proto_err(proto_err)
  );

  // {is_write, addr, be, expected word}
  localparam logic [47:0] VEC [NV] = '{
    {1'b1, 10'd1,   4'b0111, 33'h1_0000_0DEF},  // R3 partial write override
    {1'b0, 10'd2,   4'b1111, 33'h1_1234_5678},  // R3 read override
    {1'b0, 10'd1,   4'b1111, 33'h0_0000_0000},  // R5 type differs
    {1'b1, 10'd2,   4'b1111, 33'h0_0000_0000},  // R5 type differs
    {1'b0, 10'd16,  4'b1111, 33'h1_AAAA_0001},  // R7 lowest slot wins
    {1'b1, 10'd32,  4'b1111, 33'h0_0000_0000},  // R6 disabled slot
    {1'b0, 10'd3,   4'b1111, 33'h0_0000_0000},  // R4 no slot
    {1'b1, 10'd1023,4'b0000, 33'h0_0000_0000},  // R11 zero byte enable
    {1'b1, 10'd1023,4'b1000, 33'h1_FFFF_FFFF}   // R11 partial byte enable
  };

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic prog(input int idx, input logic en, input logic [9:0] a,
                      input logic wr, input logic [31:0] v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 3'(idx); tbl_en = en; tbl_addr = a; tbl_is_write = wr; tbl_value = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic do_req(input logic wr, input logic [9:0] a, input logic [3:0] be,
                        output logic gv, output logic [32:0] gd, output logic after);
    @(negedge clk);
    req_valid = 1'b1; req_is_write = wr; req_addr = a; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; tbl_we = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    gv = rsp_valid; gd = rsp_data;
    @(negedge clk);
    after = rsp_valid;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    logic gv, after;
    logic [32:0] gd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid", {32'd0, rsp_valid}, 33'd0);
    chk("R1 proto_err", {32'd0, proto_err}, 33'd0);
    chk("R10 idle data", rsp_data, 33'd0);
    do_req(1'b1, 10'd1, 4'b1111, gv, gd, after);
    chk("R1 cleared table", gd, 33'd0);
    chk("R2 strobe", {32'd0, gv}, 33'd1);

    prog(0, 1'b1, 10'd1,    1'b1, 32'h0000_0DEF);
    prog(1, 1'b1, 10'd2,    1'b0, 32'h1234_5678);
    prog(2, 1'b1, 10'd16,   1'b0, 32'hAAAA_0001);
    prog(3, 1'b1, 10'd16,   1'b0, 32'hBBBB_0002);
    prog(4, 1'b0, 10'd32,   1'b1, 32'h0000_CCCC);
    prog(5, 1'b1, 10'd1023, 1'b1, 32'hFFFF_FFFF);

    for (int i = 0; i < NV; i++) begin
      do_req(VEC[i][47], VEC[i][46:37], VEC[i][36:33], gv, gd, after);
      chk("R2 strobe high", {32'd0, gv}, 33'd1);
      chk("R3/R4/R5/R6/R7/R11 word", gd, VEC[i][32:0]);
      chk("R2 strobe one cycle", {32'd0, after}, 33'd0);
      chk("R10 data zero after", rsp_data, 33'd0);
    end

    // R9: table write on the accepting edge
    @(negedge clk);
    req_valid = 1'b1; req_is_write = 1'b1; req_addr = 10'd1; req_be = 4'b1111;
    tbl_we = 1'b1; tbl_idx = 3'd0; tbl_en = 1'b1; tbl_addr = 10'd1; tbl_is_write = 1'b1; tbl_value = 32'h0000_0111;
    @(negedge clk);
    req_valid = 1'b0; tbl_we = 1'b0;
    repeat (LAT - 1) @(negedge clk);
    chk("R9 old value used", rsp_data, 33'h1_0000_0DEF);
    do_req(1'b1, 10'd1, 4'b1111, gv, gd, after);
    chk("R9 new value later", gd, 33'h1_0000_0111);

    // R8: overlapping request during the response cycle
    @(negedge clk);
    req_valid = 1'b1; req_is_write = 1'b0; req_addr = 10'd2; req_be = 4'b1111;
    @(negedge clk);
    req_addr = 10'd16;
    repeat (LAT - 1) @(negedge clk);
    chk("R8 first response", rsp_data, 33'h1_1234_5678);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 error set", {32'd0, proto_err}, 33'd1);
    begin
      int extra = 0;
      repeat (LAT + 3) begin
        if (rsp_valid) extra++;
        @(negedge clk);
      end
      chk("R8 dropped request", 33'(extra), 33'd0);
    end
    do_req(1'b0, 10'd2, 4'b1111, gv, gd, after);
    chk("R8 legal after error", gd, 33'h1_1234_5678);
    chk("R8 error sticky", {32'd0, proto_err}, 33'd1);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 error cleared", {32'd0, proto_err}, 33'd0);
    do_req(1'b0, 10'd2, 4'b1111, gv, gd, after);
    chk("R1 table cleared by reset", gd, 33'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule